// File: doc/BRIEF.md
# Bit-Serial Program Sequencer with Return Stack

This block produces the instruction address for a program store of 512 words, each 13 bits wide. The program counter lives in a 9-bit shift register. Every new address is built one bit per clock, least significant bit first. While the counter's own bits rotate out, a half-adder with a one-bit carry register forms the counter plus one. The new bit shifted in at the top comes from one of three places: that incrementer, a branch target, or the popped stack entry.

A complete update takes nine clocks. When the address is complete, `addr_valid` is high for one cycle. In that cycle the sequencer samples its branch inputs:
- the 3-bit branch kind,
- the condition flag,
- the 9-bit target,
- the interrupt request.

Inputs in any other cycle are ignored. There is no back-pressure. `addr_valid` is a strobe, and the ROM and decoder must supply the branch kind for the new address within that same cycle.

A return stack three entries deep holds return addresses. Call and interrupt fill the new top entry serially with the incremented counter during the update. A restart kind, or the `hard_rst` pin, puts the counter back to zero and empties the stack.

Top module: `prog_seq`

## Requirements
- R1: After `rst_n` is released, `addr_valid` is high with address 0. The address is {`col_sel`[5:0], `word_sel`[2:0]`}`. `word_sel`[0] is the even/odd row select and is the first bit built.
- R2: `addr_valid` is high for exactly one cycle in every nine. Branch inputs are sampled only in that cycle. Values on them in the other eight cycles have no effect on the next address.
- R3: Branch kind 0 (step) gives the current address plus one, modulo 512. From 511 it wraps to 0.
- R4: Branch kind 1 (jump) gives `br_target`.
- R5: Branch kind 2 (call) gives `br_target` and pushes the current address plus one.
- R6: Branch kind 3 (return) gives the top stack entry and removes it.
- R7: Kinds 4, 5 and 6 act as jump, call and return when `br_cond` is 1. They act as step when `br_cond` is 0.
- R8: `irq` high in a valid cycle gives address `IRQ_VEC` (default 448) and pushes the current address plus one. It overrides kinds 0 to 6.
- R9: Kind 7 (restart) gives address 0 and empties the stack. It overrides `irq`.
- R10: `hard_rst` high in any cycle makes the next cycle a valid cycle with address 0 and an empty stack.
- R11: A push onto a full stack discards the oldest entry. The three newest entries are then returned in last-in, first-out order.
- R12: A return from an empty stack gives address 0 and leaves the stack empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hard_rst | input | 1 | Synchronous restart: counter to 0, stack emptied |
| br_kind | input | 3 | Next-address kind, sampled when addr_valid is high |
| br_cond | input | 1 | Condition for kinds 4 to 6 |
| br_target | input | 9 | Jump and call destination |
| irq | input | 1 | Interrupt request, sampled when addr_valid is high |
| col_sel | output | 6 | ROM column select, address bits 8 to 3 |
| word_sel | output | 3 | Word within column, address bits 2 to 0 |
| addr_valid | output | 1 | Address complete, branch inputs sampled this cycle |

## Verification
The assertions check the following on every cycle:
- the one-in-nine spacing of the valid strobe;
- the zero address that follows `hard_rst`;
- the result of every step, against a value captured at the previous strobe;
- the stack depth staying pinned at full on overflow and at empty on underflow.

Only the bench's scenarios can show the rest. That covers the values that come back through return, which needs a chain of calls and returns, and the address discarded on overflow. It also covers the priority between `irq`, restart and the other kinds, and the fact that input changes between strobes have no effect.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;
  typedef enum logic [2:0] {
    BR_STEP    = 3'd0,
    BR_JUMP    = 3'd1,
    BR_CALL    = 3'd2,
    BR_RET     = 3'd3,
    BR_JUMP_IF = 3'd4,
    BR_CALL_IF = 3'd5,
    BR_RET_IF  = 3'd6,
    BR_RESTART = 3'd7
  } br_kind_e;
endpackage

// File: rtl/seq_phase.sv
module seq_phase #(
  parameter int W = 9,
  localparam int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic first
);
  logic [PW-1:0] ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ph <= '0;
    else if (clr)                   ph <= '0;
    else if (ph == PW'(W - 1))      ph <= '0;
    else                            ph <= ph + PW'(1);
  end

  assign first = (ph == '0);
endmodule

// File: rtl/seq_serial_inc.sv
module seq_serial_inc (
  input  logic clk,
  input  logic rst_n,
  input  logic first,
  input  logic bit_in,
  output logic sum
);
  logic carry_q;
  logic cin;

  assign cin = first ? 1'b1 : carry_q;
  assign sum = bit_in ^ cin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry_q <= 1'b0;
    else        carry_q <= bit_in & cin;
  end
endmodule

// File: rtl/seq_ret_stack.sv
module seq_ret_stack #(
  parameter int W     = 9,
  parameter int DEPTH = 3,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic          fill,
  input  logic          ser_bit,
  output logic [W-1:0]  top,
  output logic [DW-1:0] depth
);
  logic [W-1:0] ent [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
    end else begin
      if (push) begin
        for (int i = DEPTH - 1; i > 0; i--) ent[i] <= ent[i-1];
      end else if (pop) begin
        for (int i = 0; i < DEPTH - 1; i++) ent[i] <= ent[i+1];
        ent[DEPTH-1] <= '0;
      end
      if (push || fill) ent[0] <= {ser_bit, ent[0][W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  depth <= '0;
    else if (clr)                                depth <= '0;
    else if (push && depth != DW'(DEPTH))        depth <= depth + DW'(1);
    else if (pop && depth != '0)                 depth <= depth - DW'(1);
  end

  assign top = (depth != '0) ? ent[0] : '0;

  // R11
  full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr && depth == DW'(DEPTH)) |=> (depth == DW'(DEPTH)));

  // R12
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clr && depth == '0) |=> (depth == '0));

  // R11
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr) |=> (depth != '0));
endmodule

// File: rtl/prog_seq.sv
module prog_seq
  import prog_seq_pkg::*;
#(
  parameter int AW          = 9,
  parameter int COL_W       = 6,
  parameter int DEPTH       = 3,
  parameter logic [8:0] IRQ_VEC = 9'd448,
  localparam int WORD_W     = AW - COL_W,
  localparam int DW         = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hard_rst,
  input  logic [2:0]        br_kind,
  input  logic              br_cond,
  input  logic [AW-1:0]     br_target,
  input  logic              irq,
  output logic [COL_W-1:0]  col_sel,
  output logic [WORD_W-1:0] word_sel,
  output logic              addr_valid
);
  logic          first;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] src_q;
  logic          inc_q, push_q;
  logic          inc_d, push_d, pop_d, clr_d;
  logic [AW-1:0] load_d;
  logic [AW-1:0] stk_top;
  logic [DW-1:0] stk_depth;
  logic          sum_bit, cur_inc, src_bit, new_bit;
  br_kind_e      kind;

  assign kind = br_kind_e'(br_kind);

  seq_phase #(.W(AW)) u_phase (
    .clk(clk), .rst_n(rst_n), .clr(hard_rst), .first(first)
  );

  seq_serial_inc u_inc (
    .clk(clk), .rst_n(rst_n), .first(first), .bit_in(pc_q[0]), .sum(sum_bit)
  );

  always_comb begin
    inc_d  = 1'b0;
    push_d = 1'b0;
    pop_d  = 1'b0;
    clr_d  = 1'b0;
    load_d = '0;
    if (kind == BR_RESTART) begin
      clr_d = 1'b1;
    end else if (irq) begin
      push_d = 1'b1;
      load_d = IRQ_VEC;
    end else begin
      case (kind)
        BR_JUMP:    load_d = br_target;
        BR_CALL:    begin load_d = br_target; push_d = 1'b1; end
        BR_RET:     begin load_d = stk_top;   pop_d  = 1'b1; end
        BR_JUMP_IF: begin
          if (br_cond) load_d = br_target;
          else         inc_d  = 1'b1;
        end
        BR_CALL_IF: begin
          if (br_cond) begin load_d = br_target; push_d = 1'b1; end
          else         inc_d = 1'b1;
        end
        BR_RET_IF: begin
          if (br_cond) begin load_d = stk_top; pop_d = 1'b1; end
          else         inc_d = 1'b1;
        end
        default:    inc_d = 1'b1;
      endcase
    end
  end

  seq_ret_stack #(.W(AW), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .clr(hard_rst || (first && clr_d)),
    .push(first && push_d && !hard_rst),
    .pop(first && pop_d && !hard_rst),
    .fill(!first && push_q),
    .ser_bit(sum_bit),
    .top(stk_top),
    .depth(stk_depth)
  );

  assign cur_inc = first ? inc_d : inc_q;
  assign src_bit = first ? load_d[0] : src_q[0];
  assign new_bit = cur_inc ? sum_bit : src_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0; src_q <= '0; inc_q <= 1'b0; push_q <= 1'b0;
    end else if (hard_rst) begin
      pc_q <= '0; src_q <= '0; inc_q <= 1'b0; push_q <= 1'b0;
    end else begin
      pc_q <= {new_bit, pc_q[AW-1:1]};
      if (first) begin
        src_q  <= load_d >> 1;
        inc_q  <= inc_d;
        push_q <= push_d;
      end else begin
        src_q  <= src_q >> 1;
      end
    end
  end

  assign col_sel    = pc_q[AW-1:WORD_W];
  assign word_sel   = pc_q[WORD_W-1:0];
  assign addr_valid = first;

  logic [AW-1:0] chk_exp_q;
  logic          chk_arm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                chk_arm_q <= 1'b0;
    else if (hard_rst)         chk_arm_q <= 1'b0;
    else if (addr_valid)       chk_arm_q <= (kind == BR_STEP) && !irq;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                chk_exp_q <= '0;
    else if (addr_valid)       chk_exp_q <= {col_sel, word_sel} + AW'(1);
  end

  // R2
  valid_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !hard_rst) |=> !addr_valid);

  // R10
  hard_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst |=> (addr_valid && col_sel == '0 && word_sel == '0));

  // R3
  step_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && chk_arm_q) |-> ({col_sel, word_sel} == chk_exp_q));
endmodule

// File: tb/tb_prog_seq.sv
module tb_prog_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] VEC = 9'd448;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hard_rst = 1'b0;
  logic [2:0] br_kind = 3'd0;
  logic       br_cond = 1'b0;
  logic [8:0] br_target = 9'd0;
  logic       irq = 1'b0;
  logic [5:0] col_sel;
  logic [2:0] word_sel;
  logic       addr_valid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [8:0] m_pc;
  logic [8:0] m_stk [3];
  int         m_depth;
  string      pend_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_seq dut (
    .clk(clk), .rst_n(rst_n), .hard_rst(hard_rst), .br_kind(br_kind),
    .br_cond(br_cond), .br_target(br_target), .irq(irq),
    .col_sel(col_sel), .word_sel(word_sel), .addr_valid(addr_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void m_push(input logic [8:0] v);
    m_stk[2] = m_stk[1];
    m_stk[1] = m_stk[0];
    m_stk[0] = v;
    if (m_depth < 3) m_depth++;
  endfunction

  function automatic logic [8:0] m_pop();
    logic [8:0] v;
    if (m_depth == 0) return 9'd0;
    v = m_stk[0];
    m_stk[0] = m_stk[1];
    m_stk[1] = m_stk[2];
    m_depth--;
    return v;
  endfunction

  function automatic string tag_of(input logic [2:0] k, input logic c, input logic i);
    if (k == 3'd7) return "R9";
    if (i) return "R8";
    if (k >= 3'd4) return "R7";
    case (k)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic void m_update(input logic [2:0] k, input logic c,
                                   input logic [8:0] t, input logic i);
    logic [8:0] nxt;
    nxt = m_pc + 9'd1;
    if (k == 3'd7) begin
      m_pc = 9'd0; m_depth = 0;
    end else if (i) begin
      m_push(nxt); m_pc = VEC;
    end else begin
      case (k)
        3'd1: m_pc = t;
        3'd2: begin m_push(nxt); m_pc = t; end
        3'd3: m_pc = m_pop();
        3'd4: m_pc = c ? t : nxt;
        3'd5: if (c) begin m_push(nxt); m_pc = t; end else m_pc = nxt;
        3'd6: m_pc = c ? m_pop() : nxt;
        default: m_pc = nxt;
      endcase
    end
  endfunction

  task automatic check_addr();
    chk(addr_valid === 1'b1, {pend_tag, " valid"}, int'(addr_valid), 1);
    chk({col_sel, word_sel} === m_pc, pend_tag, int'({col_sel, word_sel}), int'(m_pc));
  endtask

  task automatic do_op(input logic [2:0] k, input logic c, input logic [8:0] t,
                       input logic i, input string tag);
    check_addr();
    br_kind = k; br_cond = c; br_target = t; irq = i;
    @(posedge clk);
    m_update(k, c, t, i);
    pend_tag = tag;
    @(negedge clk);
    for (int n = 1; n < 9; n++) begin
      chk(addr_valid === 1'b0, "R2 gap", int'(addr_valid), 0);
      br_kind = 3'($urandom); br_cond = 1'($urandom);
      br_target = 9'($urandom); irq = 1'($urandom);
      @(negedge clk);
    end
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'd4711);
    m_pc = 9'd0; m_depth = 0;
    for (int j = 0; j < 3; j++) m_stk[j] = 9'd0;
    pend_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_addr();
    // R3 steps and wrap
    do_op(3'd0, 0, 0, 0, "R3");
    do_op(3'd0, 0, 0, 0, "R3");
    do_op(3'd1, 0, 9'h156, 0, "R4");
    // R1 field split after jump to 0x156
    chk(col_sel === 6'h2A && word_sel === 3'd6, "R1 fields",
        int'({col_sel, word_sel}), 9'h156);
    do_op(3'd1, 0, 9'd511, 0, "R4");
    do_op(3'd0, 0, 0, 0, "R3 wrap");
    // R5 / R11 four nested calls
    do_op(3'd2, 0, 9'h020, 0, "R5");
    do_op(3'd2, 0, 9'h040, 0, "R5");
    do_op(3'd2, 0, 9'h060, 0, "R5");
    do_op(3'd2, 0, 9'h080, 0, "R11 push full");
    do_op(3'd3, 0, 0, 0, "R6");
    do_op(3'd3, 0, 0, 0, "R11");
    do_op(3'd3, 0, 0, 0, "R11");
    do_op(3'd3, 0, 0, 0, "R12 empty pop");
    do_op(3'd3, 0, 0, 0, "R12 empty pop");
    // R7 conditional forms
    do_op(3'd4, 0, 9'h1AA, 0, "R7");
    do_op(3'd4, 1, 9'h1AA, 0, "R7");
    do_op(3'd5, 0, 9'h0F0, 0, "R7");
    do_op(3'd5, 1, 9'h0F0, 0, "R7");
    do_op(3'd6, 0, 0, 0, "R7");
    do_op(3'd6, 1, 0, 0, "R7");
    // R8 interrupt overrides jump, then return
    do_op(3'd1, 0, 9'h033, 1, "R8");
    do_op(3'd3, 0, 0, 0, "R8 return");
    // R9 restart overrides irq, empties stack
    do_op(3'd2, 0, 9'h077, 0, "R5");
    do_op(3'd7, 0, 0, 1, "R9");
    do_op(3'd3, 0, 0, 0, "R9 stack empty");
    // R10 hard reset mid-update
    do_op(3'd2, 0, 9'h0AB, 0, "R5");
    check_addr();
    br_kind = 3'd1; br_target = 9'h155; irq = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    hard_rst = 1'b1;
    @(negedge clk);
    hard_rst = 1'b0;
    m_pc = 9'd0; m_depth = 0;
    pend_tag = "R10";
    do_op(3'd3, 0, 0, 0, "R10 stack empty");
    // random mix
    for (int r = 0; r < 300; r++) begin
      logic [2:0] k;
      logic c, i;
      logic [8:0] t;
      k = 3'($urandom);
      if (k == 3'd7 && ($urandom % 4) != 0) k = 3'd0;
      c = 1'($urandom);
      i = (($urandom % 8) == 0);
      t = 9'($urandom);
      do_op(k, c, t, i, tag_of(k, c, i));
    end
    check_addr();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule